// File: doc/BRIEF.md
# Coprocessor Register Scan Port

This block is a test data register that sits beside an existing TAP controller. It gives an external debugger read and write access to the system coprocessor registers of a halted core. The TAP supplies one-cycle capture, shift and update strobes, a chain-select line and serial data in. The block returns serial data out together with an output-enable. On the core side it drives a simple register-file request port, and it waits for that port to answer with a done pulse.

The debugger opens a transfer with one 48-bit scan that has the access bit set. It then repeats scans with the access bit clear until the captured access bit reads 1. For a read, the data field of that same capture holds the register value. The shift register updates only while its chain is selected and the matching strobe is active. At all other times it keeps its contents and the serial output is forced low.

Top module: `cpreg_scan_port`

## Requirements
- R1: The chain is 48 bits long, shifted least significant bit first on both input and output. The 32-bit data word is in bits 31..0, the access bit is bit 32, the 14-bit register address is in bits 46..33 and the write flag is bit 47. Capture loads zeros into bits 47..33.
- R2: The register address on `cp_addr` carries the first opcode in bits 13..11, the second opcode in bits 10..8, the primary register number in bits 7..4 and the secondary register number in bits 3..0. It is taken unchanged from the scanned address field.
- R3: An update with the access bit at 1 starts a transfer. With the write flag at 1 it writes the data field to the addressed register. With the write flag at 0 it reads that register.
- R4: An update with the access bit at 0 starts no transfer, changes no register and leaves the completion status as it was.
- R5: On capture, bit 32 is 1 once the most recent transfer has finished and 0 while it is still outstanding.
- R6: When a finished transfer was a read, bits 31..0 of the capture hold the value the register port returned for it.
- R7: While a request is outstanding, `cp_req` stays high and address, write flag and write data stay stable. `cp_req` falls in the cycle after `cp_done` is seen.
- R8: Starting a transfer clears the completion status. TAP reset clears it, clears the shift register and drops any request, so a capture after reset reads all zeros.
- R9: When the chain is not selected, or no shift is active, `tdo_en` and `tdo` are 0. The shift register keeps its contents unless a capture or shift strobe arrives while the chain is selected.
- R10: An update with the access bit at 1 that arrives while a transfer is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_rst_n | input | 1 | Active-low asynchronous TAP reset |
| chain_sel | input | 1 | This data register is the selected chain |
| capture_dr | input | 1 | Capture strobe (one cycle) |
| shift_dr | input | 1 | Shift strobe, one bit per cycle |
| update_dr | input | 1 | Update strobe (one cycle) |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, 0 when not driving |
| tdo_en | output | 1 | Serial output is valid |
| cp_req | output | 1 | Register access request |
| cp_addr | output | 14 | Packed register address |
| cp_wr | output | 1 | 1 = write, 0 = read |
| cp_wdata | output | 32 | Write data |
| cp_rdata | input | 32 | Read data from the register file |
| cp_done | input | 1 | Register file finished the request |

## Verification
The bench runs the register-file model at zero latency, at several random latencies up to 20 cycles, and at a very long latency. A design that reports completion too early shows up in the first poll after a long-latency launch. A design that latches read data at the wrong moment returns stale data at zero latency. A second launch scanned while a long transfer is still outstanding would, in a design lacking the busy gate, reach the register port and overwrite a register the bench reads back later. A chain that shifts or drives while deselected corrupts a pattern that the bench parks in it and recovers on a later scan without capture.

// File: rtl/cpscan_pkg.sv
package cpscan_pkg;

  localparam int CP_DATA_W = 32;
  localparam int CP_ADDR_W = 14;

  // Request record held toward the register file
  typedef struct packed {
    logic                 wr;
    logic [CP_ADDR_W-1:0] addr;
    logic [CP_DATA_W-1:0] data;
  } cp_req_t;

  // Packed address layout: op1[13:11] op2[10:8] crn[7:4] crm[3:0]
  function automatic logic [CP_ADDR_W-1:0] cp_pack_addr(
    input logic [2:0] op1, input logic [2:0] op2,
    input logic [3:0] crn, input logic [3:0] crm);
    return {op1, op2, crn, crm};
  endfunction

endpackage

// File: rtl/cpscan_chain.sv
module cpscan_chain #(
  parameter int DATA_W = cpscan_pkg::CP_DATA_W,
  parameter int ADDR_W = cpscan_pkg::CP_ADDR_W,
  localparam int CHAIN_W = DATA_W + ADDR_W + 2
) (
  input  logic               tck,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               capture,
  input  logic               shift,
  input  logic               tdi,
  input  logic [CHAIN_W-1:0] cap_word,
  output logic [CHAIN_W-1:0] word_o,
  output logic               tdo,
  output logic               tdo_en
);

  logic [CHAIN_W-1:0] sr_q;
  logic               cap_evt;
  logic               shf_evt;

  assign cap_evt = sel && capture;
  assign shf_evt = sel && shift && !capture;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (cap_evt) begin
      sr_q <= cap_word;
    end else if (shf_evt) begin
      sr_q <= {tdi, sr_q[CHAIN_W-1:1]};
    end
  end

  assign tdo_en = sel && shift;
  assign tdo    = tdo_en ? sr_q[0] : 1'b0;
  assign word_o = sr_q;

  AST_HOLD_UNSEL: assert property (@(posedge tck) disable iff (!rst_n)
    !(sel && (capture || shift)) |=> $stable(sr_q)); // R9

endmodule

// File: rtl/cpscan_xfer.sv
module cpscan_xfer #(
  parameter int DATA_W = cpscan_pkg::CP_DATA_W,
  parameter int ADDR_W = cpscan_pkg::CP_ADDR_W,
  localparam int CHAIN_W  = DATA_W + ADDR_W + 2,
  localparam int ACC_POS  = DATA_W,
  localparam int ADDR_LSB = DATA_W + 1,
  localparam int WR_POS   = CHAIN_W - 1
) (
  input  logic               tck,
  input  logic               rst_n,
  input  logic               upd_en,
  input  logic [CHAIN_W-1:0] word_i,
  output logic               cp_req,
  output logic [ADDR_W-1:0]  cp_addr,
  output logic               cp_wr,
  output logic [DATA_W-1:0]  cp_wdata,
  input  logic [DATA_W-1:0]  cp_rdata,
  input  logic               cp_done,
  output logic               complete_o,
  output logic [DATA_W-1:0]  rdbuf_o
);

  function automatic logic f_access(input logic [CHAIN_W-1:0] w);
    return w[ACC_POS];
  endfunction

  function automatic logic [ADDR_W-1:0] f_addr(input logic [CHAIN_W-1:0] w);
    return w[ADDR_LSB +: ADDR_W];
  endfunction

  function automatic logic f_write(input logic [CHAIN_W-1:0] w);
    return w[WR_POS];
  endfunction

  logic              req_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              complete_q;
  logic [DATA_W-1:0] rdbuf_q;
  logic              launch_evt;
  logic              finish_evt;

  assign launch_evt = upd_en && f_access(word_i) && !req_q;
  assign finish_evt = req_q && cp_done;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= 1'b0;
      wr_q       <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      complete_q <= 1'b0;
      rdbuf_q    <= '0;
    end else if (launch_evt) begin
      req_q      <= 1'b1;
      wr_q       <= f_write(word_i);
      addr_q     <= f_addr(word_i);
      wdata_q    <= word_i[DATA_W-1:0];
      complete_q <= 1'b0;
    end else if (finish_evt) begin
      req_q      <= 1'b0;
      complete_q <= 1'b1;
      if (!wr_q) rdbuf_q <= cp_rdata;
    end
  end

  assign cp_req     = req_q;
  assign cp_wr      = wr_q;
  assign cp_addr    = addr_q;
  assign cp_wdata   = wdata_q;
  assign complete_o = complete_q;
  assign rdbuf_o    = rdbuf_q;

  AST_REQ_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    (cp_req && !cp_done) |=> (cp_req && $stable(cp_addr) && $stable(cp_wr) && $stable(cp_wdata))); // R7

  AST_REQ_DROP: assert property (@(posedge tck) disable iff (!rst_n)
    (cp_req && cp_done) |=> (!cp_req && complete_o)); // R5

  AST_LAUNCH_CLEARS: assert property (@(posedge tck) disable iff (!rst_n)
    launch_evt |=> (cp_req && !complete_o)); // R8

  AST_LAUNCH_DIR: assert property (@(posedge tck) disable iff (!rst_n)
    launch_evt |=> (cp_wr == $past(word_i[WR_POS]))); // R3

  AST_BUSY_IGNORE: assert property (@(posedge tck) disable iff (!rst_n)
    (upd_en && cp_req && !cp_done) |=> $stable(cp_addr)); // R10

  AST_NOP_QUIET: assert property (@(posedge tck) disable iff (!rst_n)
    (upd_en && !word_i[ACC_POS] && !cp_req) |=> !cp_req); // R4

endmodule

// File: rtl/cpreg_scan_port.sv
module cpreg_scan_port #(
  parameter int DATA_W = cpscan_pkg::CP_DATA_W,
  parameter int ADDR_W = cpscan_pkg::CP_ADDR_W,
  localparam int CHAIN_W = DATA_W + ADDR_W + 2
) (
  input  logic              tck,
  input  logic              tap_rst_n,
  input  logic              chain_sel,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_en,
  output logic              cp_req,
  output logic [ADDR_W-1:0] cp_addr,
  output logic              cp_wr,
  output logic [DATA_W-1:0] cp_wdata,
  input  logic [DATA_W-1:0] cp_rdata,
  input  logic              cp_done
);

  // Capture word: zeros above the status bit, status, then read buffer
  function automatic logic [CHAIN_W-1:0] f_capture(
    input logic [DATA_W-1:0] rd, input logic fin);
    return {{(ADDR_W+1){1'b0}}, fin, rd};
  endfunction

  logic [CHAIN_W-1:0] cap_word;
  logic [CHAIN_W-1:0] chain_word;
  logic               complete;
  logic [DATA_W-1:0]  rdbuf;
  logic               upd_en;

  assign cap_word = f_capture(rdbuf, complete);
  assign upd_en   = chain_sel && update_dr;

  cpscan_chain #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chain (
    .tck      (tck),
    .rst_n    (tap_rst_n),
    .sel      (chain_sel),
    .capture  (capture_dr),
    .shift    (shift_dr),
    .tdi      (tdi),
    .cap_word (cap_word),
    .word_o   (chain_word),
    .tdo      (tdo),
    .tdo_en   (tdo_en)
  );

  cpscan_xfer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_xfer (
    .tck        (tck),
    .rst_n      (tap_rst_n),
    .upd_en     (upd_en),
    .word_i     (chain_word),
    .cp_req     (cp_req),
    .cp_addr    (cp_addr),
    .cp_wr      (cp_wr),
    .cp_wdata   (cp_wdata),
    .cp_rdata   (cp_rdata),
    .cp_done    (cp_done),
    .complete_o (complete),
    .rdbuf_o    (rdbuf)
  );

  AST_TDO_IDLE: assert property (@(posedge tck) disable iff (!tap_rst_n)
    !(chain_sel && shift_dr) |-> (!tdo_en && !tdo)); // R9

  AST_ADDR_FROM_CHAIN: assert property (@(posedge tck) disable iff (!tap_rst_n)
    (upd_en && chain_word[DATA_W] && !cp_req) |=> (cp_addr == $past(chain_word[DATA_W+1 +: ADDR_W]))); // R2

endmodule

// File: tb/cpreg_scan_port_bench.sv
module cpreg_scan_port_bench;

  localparam int TCK_PERIOD = 10;

  logic        tck = 1'b0;
  logic        tap_rst_n = 1'b0;
  logic        chain_sel = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic        tdo, tdo_en, cp_req, cp_wr, cp_done;
  logic [13:0] cp_addr;
  logic [31:0] cp_wdata, cp_rdata;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #(TCK_PERIOD/2) tck = ~tck;

  cpreg_scan_port u_cpreg_scan_port (
    .tck(tck), .tap_rst_n(tap_rst_n), .chain_sel(chain_sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .cp_req(cp_req), .cp_addr(cp_addr), .cp_wr(cp_wr), .cp_wdata(cp_wdata),
    .cp_rdata(cp_rdata), .cp_done(cp_done)
  );

  // ---------------- bench functions ----------------
  function automatic logic [13:0] b_pack(input int op1, input int op2, input int crn, input int crm);
    return 14'((op1 % 8) * 2048 + (op2 % 8) * 256 + (crn % 16) * 16 + (crm % 16));
  endfunction

  function automatic logic [31:0] b_init(input int idx);
    return 32'h5A00_0000 + 32'(idx) * 32'h0001_0203;
  endfunction

  function automatic int b_idx(input logic [13:0] a);
    return int'(a[6:4]) * 8 + int'(a[2:0]);
  endfunction

  function automatic logic [47:0] b_frame(input bit acc, input bit wr, input logic [13:0] a, input logic [31:0] d);
    logic [47:0] f;
    f = '0;
    for (int i = 0; i < 32; i++) f[i] = d[i];
    f[32] = acc;
    for (int i = 0; i < 14; i++) f[33 + i] = a[i];
    f[47] = wr;
    return f;
  endfunction

  // ---------------- register-file model ----------------
  logic [31:0] mem [0:63];
  int lat = 0;
  int cnt = 0;
  int req_starts = 0;
  int mon_errs = 0;
  logic [13:0] last_addr = '0;
  logic        prev_busy = 1'b0;
  logic [13:0] prev_addr = '0;
  logic        prev_req = 1'b0;

  assign cp_done  = cp_req && (cnt == lat);
  assign cp_rdata = mem[b_idx(cp_addr)];

  always @(posedge tck) begin
    if (cp_req && !cp_done) cnt <= cnt + 1; else cnt <= 0;
    if (cp_req && cp_done) begin
      last_addr <= cp_addr;
      if (cp_wr) mem[b_idx(cp_addr)] <= cp_wdata;
    end
    if (cp_req && !prev_req) req_starts <= req_starts + 1;
    // R7: request fields must not move while waiting
    if (prev_busy && (!cp_req || cp_addr != prev_addr)) mon_errs <= mon_errs + 1;
    prev_busy <= cp_req && !cp_done;
    prev_addr <= cp_addr;
    prev_req  <= cp_req;
  end

  // ---------------- check and scan tasks ----------------
  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic scan(input logic [47:0] din, input bit cap, output logic [47:0] dout);
    dout = '0;
    @(negedge tck);
    chain_sel = 1'b1;
    if (cap) begin
      capture_dr = 1'b1;
      @(negedge tck);
      capture_dr = 1'b0;
    end
    for (int i = 0; i < 48; i++) begin
      shift_dr = 1'b1;
      tdi = din[i];
      #1 dout[i] = tdo;
      @(negedge tck);
    end
    shift_dr  = 1'b0;
    update_dr = 1'b1;
    @(negedge tck);
    update_dr = 1'b0;
  endtask

  task automatic poll(output logic [47:0] last, output int n);
    n = 0;
    last = '0;
    while (n < 300) begin
      scan(48'h0, 1'b1, last);
      n++;
      if (last[32]) break;
    end
  endtask

  logic [13:0] tbl [0:7];
  logic [31:0] shadow [0:7];

  task automatic do_read(input int k, input string req);
    logic [47:0] o;
    int n;
    scan(b_frame(1'b1, 1'b0, tbl[k], 32'hFFFF_FFFF), 1'b1, o);
    poll(o, n);
    chk(o[32] == 1'b1, "R5", 64'(o[32]), 64'd1);
    chk(o[31:0] == shadow[k], req, 64'(o[31:0]), 64'(shadow[k]));
    chk(o[47:33] == 15'd0, "R1", 64'(o[47:33]), 64'd0);
    chk(last_addr == tbl[k], "R2", 64'(last_addr), 64'(tbl[k]));
  endtask

  task automatic do_write(input int k, input logic [31:0] d);
    logic [47:0] o;
    int n;
    scan(b_frame(1'b1, 1'b1, tbl[k], d), 1'b1, o);
    poll(o, n);
    shadow[k] = d;
    chk(o[32] == 1'b1, "R3", 64'(o[32]), 64'd1);
    chk(last_addr == tbl[k], "R2", 64'(last_addr), 64'(tbl[k]));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(TCK_PERIOD * 190000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [47:0] o;
    logic [47:0] pat;
    int n, starts0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) mem[i] = b_init(i);
    for (int k = 0; k < 8; k++) begin
      tbl[k] = b_pack(int'($urandom % 8), int'($urandom % 8), k, 7 - k);
      shadow[k] = b_init(b_idx(tbl[k]));
    end

    repeat (3) @(negedge tck);
    tap_rst_n = 1'b1;
    @(negedge tck);
    chk(cp_req == 1'b0, "R8", 64'(cp_req), 64'd0);
    chk(tdo_en == 1'b0, "R9", 64'(tdo_en), 64'd0);
    scan(48'h0, 1'b1, o);
    chk(o == 48'h0, "R8", 64'(o), 64'd0);
    chk(req_starts == 0, "R4", 64'(req_starts), 64'd0);

    // zero latency read: done by first poll
    lat = 0;
    scan(b_frame(1'b1, 1'b0, tbl[2], 32'h0), 1'b1, o);
    scan(48'h0, 1'b1, o);
    chk(o[32] == 1'b1, "R5", 64'(o[32]), 64'd1);
    chk(o[31:0] == shadow[2], "R6", 64'(o[31:0]), 64'(shadow[2]));

    // long latency read: first poll busy, launch cleared status
    lat = 20;
    scan(b_frame(1'b1, 1'b0, tbl[5], 32'h0), 1'b1, o);
    scan(48'h0, 1'b1, o);
    chk(o[32] == 1'b0, "R8", 64'(o[32]), 64'd0);
    poll(o, n);
    chk(o[31:0] == shadow[5], "R6", 64'(o[31:0]), 64'(shadow[5]));
    chk(n >= 1, "R5", 64'(n), 64'd1);

    // write then neighbour untouched
    lat = 7;
    do_write(3, 32'hCAFE_1234);
    lat = 0;
    do_read(3, "R3");
    do_read(4, "R3");

    // NOP with data payload changes nothing, keeps status
    starts0 = req_starts;
    scan(b_frame(1'b0, 1'b0, tbl[4], 32'hDEAD_BEEF), 1'b1, o);
    scan(48'h0, 1'b1, o);
    chk(req_starts == starts0, "R4", 64'(req_starts), 64'(starts0));
    chk(o[32] == 1'b1, "R4", 64'(o[32]), 64'd1);
    do_read(4, "R4");

    // launch while busy is dropped
    lat = 120;
    starts0 = req_starts;
    scan(b_frame(1'b1, 1'b1, tbl[6], 32'h1111_2222), 1'b1, o);
    scan(b_frame(1'b1, 1'b1, tbl[7], 32'h3333_4444), 1'b1, o);
    poll(o, n);
    shadow[6] = 32'h1111_2222;
    chk(req_starts == starts0 + 1, "R10", 64'(req_starts), 64'(starts0 + 1));
    lat = 0;
    do_read(7, "R10");
    do_read(6, "R10");

    // deselected / idle: hold and quiet output
    pat = b_frame(1'b0, 1'b0, 14'h2A5C, 32'h9876_5432);
    scan(pat, 1'b1, o);
    for (int i = 0; i < 10; i++) begin
      @(negedge tck);
      chain_sel = 1'b0;
      shift_dr = 1'b1;
      capture_dr = i[0];
      tdi = ~tdi;
      #1 chk(tdo_en == 1'b0 && tdo == 1'b0, "R9", 64'({tdo_en, tdo}), 64'd0);
    end
    @(negedge tck);
    shift_dr = 1'b0;
    capture_dr = 1'b0;
    chain_sel = 1'b1;
    #1 chk(tdo_en == 1'b0, "R9", 64'(tdo_en), 64'd0);
    scan(48'h0, 1'b0, o);
    chk(o == pat, "R9", 64'(o), 64'(pat));
    chk(o[32] == 1'b0 && o[47] == 1'b0, "R1", 64'({o[47], o[32]}), 64'd0);

    // random mix of reads and writes
    for (int it = 0; it < 40; it++) begin
      int k;
      k = int'($urandom % 8);
      lat = int'($urandom % 21);
      if ($urandom % 2 == 1) do_write(k, $urandom);
      else do_read(k, "R6");
    end

    chk(mon_errs == 0, "R7", 64'(mon_errs), 64'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule